// File: doc/BRIEF.md
# Key-Protected Control Register Bank

This block is a bank of 32-bit control words that sits in a 4 KB address window. It is accessed one word at a time over a plain strobe bus with a write strobe, a read strobe, a byte address, write data and read data. Ordinary control words cannot be changed until software writes a 16-bit opening key to a dedicated key port. A second key port with a different 16-bit key closes the bank again. After reset the bank is closed. A read-only word reports the current lock state.

Each word index has one access class: read-write, read-only, write-only or unmapped. When the class forbids an access, the block raises an error flag in the same cycle as the strobe. A forbidden write is dropped. A forbidden read returns zero. The block also holds a reset-control word. While the bank is open, writing that word with its lowest bit set produces a one-cycle soft-reset request, which downstream reset sequencing consumes.

The word index is taken from address bits [11:2]. The map has a one-bit scratch word at 0x000, the closing key port at 0x004, the opening key port at 0x008 and the lock state at 0x00C. It also has three clock-generator control words at 0x100 to 0x108, a generator status word at 0x10C, a serial-clock control word at 0x154, the reset-control word at 0x200, a strap word at 0x25C and a general-purpose block of NUM_GP words starting at 0x300.

Top module: `keyreg_bank`

## Requirements
- R1: After reset the lock state word (0x00C) reads 1. The clock-generator words 0x100, 0x104 and 0x108 read 0x0001A008. The serial-clock word 0x154 reads 0x00003F03. The generator status word 0x10C reads 0x0000003F. The strap word 0x25C reads MODE_VAL (default 1). Every other read-write word reads 0.
- R2: A write to 0x004 whose data bits [15:0] equal 0x767B sets the lock state to 1. Bits [31:16] are ignored, and any other value leaves the lock state unchanged.
- R3: A write to 0x008 whose data bits [15:0] equal 0xDF0D clears the lock state to 0. Bits [31:16] are ignored, and any other value leaves the lock state unchanged.
- R4: While the lock state is 1, writes to read-write words are discarded without raising the error flag. Both key ports keep working.
- R5: acc_err is high in the strobe cycle for a read of 0x004 or 0x008, for a write to a read-only word (0x00C, 0x10C, 0x25C), and for any access to an unmapped index. A forbidden or unmapped read returns 0.
- R6: A write to a read-only word changes no state. Writing 0x00C does not alter the lock state.
- R7: The scratch word at 0x000 stores only write-data bit 0 and reads back with bits [31:1] zero.
- R8: While open, a write to 0x200 with data bit 0 set stores the word and raises soft_rst_req for exactly the one cycle after the write edge. No pulse is produced when the bank is closed or when bit 0 is clear.
- R9: Address bits [1:0] are ignored. Only bits [11:2] select the word.
- R10: rdata presents the selected word combinationally in the cycle rd_en is high and is 0 whenever rd_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously by the integrator |
| wr_en | input | 1 | Write strobe, one word per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte address in the 4 KB window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the rd_en cycle |
| acc_err | output | 1 | Illegal access flag, same cycle as the strobe |
| soft_rst_req | output | 1 | One-cycle soft-reset request |

## Verification
The bound checker watches these properties on every cycle: the key ports move the lock state, the lock state holds when no key port is written, unmapped accesses raise the error flag, ordinary writes are never flagged, idle read data is zero, and every reset request has a qualifying write one cycle before it. Some behaviour only shows in the bench's scenarios, where a per-cycle reference model is compared against the design. That covers the reset values, data discarded while closed, the single-bit scratch storage, writes dropped at read-only words, address-bit aliasing and read-back of many data patterns.

// File: rtl/keyreg_pkg.sv
package keyreg_pkg;

  localparam int DW   = 32;
  localparam int IW   = 10;
  localparam int NPLL = 3;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RW   = 2'd1,
    ACC_RO   = 2'd2,
    ACC_WO   = 2'd3
  } acc_cls_e;

  typedef enum logic [1:0] {
    RO_NONE    = 2'd0,
    RO_LSTAT   = 2'd1,
    RO_PLLSTAT = 2'd2,
    RO_MODE    = 2'd3
  } ro_sel_e;

  // word indices (byte offset / 4)
  localparam logic [IW-1:0] IDX_SCR     = 10'h000;
  localparam logic [IW-1:0] IDX_LOCK    = 10'h001;
  localparam logic [IW-1:0] IDX_UNLOCK  = 10'h002;
  localparam logic [IW-1:0] IDX_LSTAT   = 10'h003;
  localparam logic [IW-1:0] IDX_PLL0    = 10'h040;
  localparam logic [IW-1:0] IDX_PLLSTAT = 10'h043;
  localparam logic [IW-1:0] IDX_UART    = 10'h055;
  localparam logic [IW-1:0] IDX_RST     = 10'h080;
  localparam logic [IW-1:0] IDX_MODE    = 10'h097;
  localparam logic [IW-1:0] IDX_GP0     = 10'h0C0;

  localparam logic [15:0] KEY_CLOSE = 16'h767B;
  localparam logic [15:0] KEY_OPEN  = 16'hDF0D;

  localparam logic [DW-1:0] PLL_RST_VAL  = 32'h0001_A008;
  localparam logic [DW-1:0] UART_RST_VAL = 32'h0000_3F03;
  localparam logic [DW-1:0] PLLSTAT_VAL  = 32'h0000_003F;

  // storage slot numbering
  localparam int SLOT_SCR  = 0;
  localparam int SLOT_PLL0 = 1;
  localparam int SLOT_UART = 1 + NPLL;
  localparam int SLOT_RST  = 2 + NPLL;
  localparam int SLOT_GP0  = 3 + NPLL;

endpackage

// File: rtl/keyreg_decode.sv
module keyreg_decode
  import keyreg_pkg::*;
#(
  parameter int NUM_GP = 8,
  localparam int NSLOT = SLOT_GP0 + NUM_GP,
  localparam int SW    = $clog2(NSLOT)
) (
  input  logic [IW-1:0] idx,
  output acc_cls_e      cls,
  output ro_sel_e       ro_sel,
  output logic [SW-1:0] slot,
  output logic          hit_close,
  output logic          hit_open
);

  localparam logic [IW-1:0] PLL_END = IW'(int'(IDX_PLL0) + NPLL);
  localparam logic [IW-1:0] GP_END  = IW'(int'(IDX_GP0) + NUM_GP);

  always_comb begin
    cls    = ACC_NONE;
    ro_sel = RO_NONE;
    slot   = '0;
    if (idx == IDX_SCR) begin
      cls  = ACC_RW;
      slot = SW'(SLOT_SCR);
    end else if (idx == IDX_LOCK || idx == IDX_UNLOCK) begin
      cls = ACC_WO;
    end else if (idx == IDX_LSTAT) begin
      cls    = ACC_RO;
      ro_sel = RO_LSTAT;
    end else if (idx >= IDX_PLL0 && idx < PLL_END) begin
      cls  = ACC_RW;
      slot = SW'(idx - IDX_PLL0) + SW'(SLOT_PLL0);
    end else if (idx == IDX_PLLSTAT) begin
      cls    = ACC_RO;
      ro_sel = RO_PLLSTAT;
    end else if (idx == IDX_UART) begin
      cls  = ACC_RW;
      slot = SW'(SLOT_UART);
    end else if (idx == IDX_RST) begin
      cls  = ACC_RW;
      slot = SW'(SLOT_RST);
    end else if (idx == IDX_MODE) begin
      cls    = ACC_RO;
      ro_sel = RO_MODE;
    end else if (idx >= IDX_GP0 && idx < GP_END) begin
      cls  = ACC_RW;
      slot = SW'(idx - IDX_GP0) + SW'(SLOT_GP0);
    end
  end

  assign hit_close = (idx == IDX_LOCK);
  assign hit_open  = (idx == IDX_UNLOCK);

endmodule

// File: rtl/keyreg_lock.sv
module keyreg_lock
  import keyreg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        hit_close,
  input  logic        hit_open,
  input  logic [15:0] key,
  output logic        locked_q
);

  logic locked_d;

  always_comb begin
    locked_d = locked_q;
    if (wr_en && hit_close && key == KEY_CLOSE) begin
      locked_d = 1'b1;
    end else if (wr_en && hit_open && key == KEY_OPEN) begin
      locked_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b1;
    end else begin
      locked_q <= locked_d;
    end
  end

endmodule

// File: rtl/keyreg_store.sv
module keyreg_store
  import keyreg_pkg::*;
#(
  parameter int NUM_GP = 8,
  localparam int NSLOT = SLOT_GP0 + NUM_GP,
  localparam int SW    = $clog2(NSLOT)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [SW-1:0]            slot,
  input  logic [DW-1:0]            wdata,
  output logic [NSLOT-1:0][DW-1:0] q
);

  function automatic logic [DW-1:0] slot_rst(int s);
    if (s >= SLOT_PLL0 && s < SLOT_PLL0 + NPLL) return PLL_RST_VAL;
    if (s == SLOT_UART) return UART_RST_VAL;
    return '0;
  endfunction

  function automatic logic [DW-1:0] slot_mask(int s);
    if (s == SLOT_SCR) return 32'h0000_0001;
    return '1;
  endfunction

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam logic [DW-1:0] RV = slot_rst(s);
    localparam logic [DW-1:0] MK = slot_mask(s);
    logic          en;
    logic [DW-1:0] d;

    assign en = we && (slot == SW'(s));
    assign d  = wdata & MK;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[s] <= RV;
      end else if (en) begin
        q[s] <= d;
      end
    end
  end

endmodule

// File: rtl/keyreg_bank.sv
module keyreg_bank
  import keyreg_pkg::*;
#(
  parameter int              NUM_GP   = 8,
  parameter logic [DW-1:0]   MODE_VAL = 32'h0000_0001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [11:0]   addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          acc_err,
  output logic          soft_rst_req
);

  localparam int NSLOT = SLOT_GP0 + NUM_GP;
  localparam int SW    = $clog2(NSLOT);

  logic [IW-1:0]            idx;
  acc_cls_e                 dec_cls;
  ro_sel_e                  dec_ro;
  logic [SW-1:0]            dec_slot;
  logic                     hit_close;
  logic                     hit_open;
  logic                     lock_q;
  logic                     wr_ok;
  logic                     rd_ok;
  logic                     st_we;
  logic [NSLOT-1:0][DW-1:0] st_q;
  logic [DW-1:0]            rd_word;
  logic                     rst_req_d;
  logic                     rst_req_q;
  logic                     unused_abits;

  assign idx          = addr[11:2];
  assign unused_abits = ^addr[1:0];

  keyreg_decode #(.NUM_GP(NUM_GP)) u_dec (
    .idx       (idx),
    .cls       (dec_cls),
    .ro_sel    (dec_ro),
    .slot      (dec_slot),
    .hit_close (hit_close),
    .hit_open  (hit_open)
  );

  keyreg_lock u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .hit_close (hit_close),
    .hit_open  (hit_open),
    .key       (wdata[15:0]),
    .locked_q  (lock_q)
  );

  assign wr_ok = (dec_cls == ACC_RW) || (dec_cls == ACC_WO);
  assign rd_ok = (dec_cls == ACC_RW) || (dec_cls == ACC_RO);
  assign st_we = wr_en && (dec_cls == ACC_RW) && !lock_q;

  keyreg_store #(.NUM_GP(NUM_GP)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (st_we),
    .slot  (dec_slot),
    .wdata (wdata),
    .q     (st_q)
  );

  always_comb begin
    case (dec_ro)
      RO_LSTAT:   rd_word = {{(DW-1){1'b0}}, lock_q};
      RO_PLLSTAT: rd_word = PLLSTAT_VAL;
      RO_MODE:    rd_word = MODE_VAL;
      default:    rd_word = st_q[dec_slot];
    endcase
  end

  assign rdata   = (rd_en && rd_ok) ? rd_word : '0;
  assign acc_err = (wr_en && !wr_ok) || (rd_en && !rd_ok);

  assign rst_req_d = st_we && (dec_slot == SW'(SLOT_RST)) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= rst_req_d;
    end
  end

  assign soft_rst_req = rst_req_q;

endmodule

// File: rtl/keyreg_bank_chk.sv
module keyreg_bank_chk
  import keyreg_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [11:0]   addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          acc_err,
  input logic          soft_rst_req,
  input logic          locked,
  input acc_cls_e      cls
);

  AST_CLOSE_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[11:2] == IDX_LOCK && wdata[15:0] == KEY_CLOSE) |=> locked); // R2

  AST_OPEN_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[11:2] == IDX_UNLOCK && wdata[15:0] == KEY_OPEN) |=> !locked); // R3

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr[11:2] == IDX_LOCK || addr[11:2] == IDX_UNLOCK)) |=> $stable(locked)); // R2

  AST_RW_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && cls == ACC_RW) |-> !acc_err); // R4

  AST_UNMAPPED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_en) && cls == ACC_NONE) |-> acc_err); // R5

  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0)); // R10

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_req |-> $past(wr_en && !locked && addr[11:2] == IDX_RST && wdata[0])); // R8

endmodule

bind keyreg_bank keyreg_bank_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .rd_en        (rd_en),
  .addr         (addr),
  .wdata        (wdata),
  .rdata        (rdata),
  .acc_err      (acc_err),
  .soft_rst_req (soft_rst_req),
  .locked       (lock_q),
  .cls          (dec_cls)
);

// File: tb/sim_keyreg_bank.sv
module sim_keyreg_bank;

  localparam int CLK_P  = 10;
  localparam int NUM_GP = 8;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        rd_en;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        acc_err;
  logic        soft_rst_req;

  int    n_cmp;
  int    n_bad;
  string cur_req;

  // reference model state
  logic [31:0] m_mem [0:1023];
  logic        m_locked;
  logic        m_pulse;

  keyreg_bank #(.NUM_GP(NUM_GP)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .addr         (addr),
    .wdata        (wdata),
    .rdata        (rdata),
    .acc_err      (acc_err),
    .soft_rst_req (soft_rst_req)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // 0 unmapped, 1 read-write, 2 read-only, 3 write-only
  function automatic int m_cls(int i);
    if (i == 0) return 1;
    if (i == 1 || i == 2) return 3;
    if (i == 3 || i == 67 || i == 151) return 2;
    if (i >= 64 && i <= 66) return 1;
    if (i == 85 || i == 128) return 1;
    if (i >= 192 && i < 192 + NUM_GP) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] m_read(int i);
    if (i == 3) return {31'b0, m_locked};
    if (i == 67) return 32'h3F;
    if (i == 151) return 32'h1;
    return m_mem[i];
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 1024; i++) m_mem[i] = '0;
    for (int i = 64; i <= 66; i++) m_mem[i] = 32'h0001_A008;
    m_mem[85] = 32'h0000_3F03;
    m_locked  = 1'b1;
    m_pulse   = 1'b0;
  endtask

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  // compare every cycle, a quarter period after the falling edge
  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (!rst_n) begin
      m_reset();
      check("rdata", rdata, 32'h0);
      check("acc_err", {31'b0, acc_err}, 32'h0);
      check("soft_rst_req", {31'b0, soft_rst_req}, 32'h0);
    end else begin
      int          i;
      int          c;
      logic        e_err;
      logic [31:0] e_rd;
      logic        nxt;
      i     = int'(addr[11:2]);
      c     = m_cls(i);
      e_err = (wr_en && !(c == 1 || c == 3)) || (rd_en && !(c == 1 || c == 2));
      e_rd  = (rd_en && (c == 1 || c == 2)) ? m_read(i) : 32'h0;
      check("rdata", rdata, e_rd);
      check("acc_err", {31'b0, acc_err}, {31'b0, e_err});
      check("soft_rst_req", {31'b0, soft_rst_req}, {31'b0, m_pulse});
      nxt = 1'b0;
      if (wr_en) begin
        if (i == 1) begin
          if (wdata[15:0] == 16'h767B) m_locked = 1'b1;
        end else if (i == 2) begin
          if (wdata[15:0] == 16'hDF0D) m_locked = 1'b0;
        end else if (c == 1 && !m_locked) begin
          m_mem[i] = (i == 0) ? (wdata & 32'h1) : wdata;
          if (i == 128 && wdata[0]) nxt = 1'b1;
        end
      end
      m_pulse = nxt;
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
  endtask

  task automatic rd(logic [11:0] a);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1; addr = a; wdata = 32'h0;
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; addr = 12'h0; wdata = 32'h0;
  endtask

  initial begin
    n_cmp = 0; n_bad = 0;
    cur_req = "R1";
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    cur_req = "R1";
    rd(12'h000); rd(12'h00C); rd(12'h100); rd(12'h104); rd(12'h108);
    rd(12'h10C); rd(12'h154); rd(12'h25C); rd(12'h200); rd(12'h300);

    // R4: closed bank discards ordinary writes, no error flag
    cur_req = "R4";
    wr(12'h154, 32'h0000_1234); rd(12'h154);
    wr(12'h300, 32'hDEAD_BEEF); rd(12'h300);

    // R3 / R2: key checks, upper half ignored
    cur_req = "R3";
    wr(12'h008, 32'h0000_DF0C); rd(12'h00C);
    wr(12'h008, 32'hABCD_DF0D); rd(12'h00C);
    cur_req = "R2";
    wr(12'h004, 32'h0000_767A); rd(12'h00C);
    wr(12'h004, 32'h5555_767B); rd(12'h00C);
    cur_req = "R4";
    wr(12'h100, 32'h0000_0001); rd(12'h100);
    cur_req = "R3";
    wr(12'h008, 32'h0000_DF0D); rd(12'h00C);

    // R7: scratch holds bit 0 only
    cur_req = "R7";
    wr(12'h000, 32'hFFFF_FFFE); rd(12'h000);
    wr(12'h000, 32'h0000_0003); rd(12'h000);

    // R9: byte-offset bits ignored
    cur_req = "R9";
    wr(12'h301, 32'h1357_9BDF); rd(12'h300); rd(12'h303);
    wr(12'h156, 32'h0000_0A55); rd(12'h154);

    // R10: data patterns in the general words, back-to-back reads
    cur_req = "R10";
    for (int g = 0; g < NUM_GP; g++) wr(12'(12'h300 + 4 * g), 32'hA5A5_0000 ^ (32'h1 << g));
    for (int g = 0; g < NUM_GP; g++) rd(12'(12'h300 + 4 * g));
    wr(12'h104, 32'h0000_0000); wr(12'h108, 32'hFFFF_FFFF);
    rd(12'h100); rd(12'h104); rd(12'h108);
    idle(); idle();

    // R5: access classes
    cur_req = "R5";
    rd(12'h004); rd(12'h008);
    wr(12'h25C, 32'h0000_0000);
    rd(12'h800); wr(12'hFFC, 32'h1234_5678); rd(12'h110); rd(12'h320);
    rd(12'h0FC);

    // R6: writes to read-only words change nothing
    cur_req = "R6";
    wr(12'h00C, 32'h0000_0001); rd(12'h00C);
    wr(12'h10C, 32'h0000_0000); rd(12'h10C);
    wr(12'h25C, 32'h0000_00FF); rd(12'h25C);

    // R8: soft-reset request
    cur_req = "R8";
    wr(12'h200, 32'h0000_0001); idle(); idle();
    wr(12'h200, 32'h0000_0002); idle(); rd(12'h200);
    wr(12'h200, 32'h0000_0001); wr(12'h200, 32'h0000_0001); idle(); idle();
    wr(12'h004, 32'h0000_767B);
    wr(12'h200, 32'h0000_0003); idle(); rd(12'h200);
    wr(12'h008, 32'h0000_DF0D);
    wr(12'h200, 32'hFFFF_FFFF); idle(); rd(12'h200);
    idle(); idle();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule